// File: doc/BRIEF.md
# Erase-Block Write-Protection Lock Manager

This block holds a protection state for every erase block of a flash array and carries out range commands that change those states. Software loads a first and a last block index into two range registers. It then strobes a command opcode. The block walks the selected range one block per clock and updates each block according to the command. A query port reports the state of any block, and whether it may be programmed, to the program and erase logic that sits beside the block.

Each block is in exactly one of three one-hot states: lock-tightened, locked or unlocked. A lock-tightened block is frozen until the next cold reset. It halts any lock or unlock walk that meets it. The lock-tight walk steps over unlocked blocks and leaves them unlocked. A status register keeps the most recent state that a walk actually changed a block to. An error flag records a walk that ran past the last existing block.

Top module: `wp_lock_mgr`

## Requirements
- R1: During and after the cold reset (rst_n low), every block reads as locked, wp_status is 0x0002, and cmd_err, busy and done are low. Both range registers read 0.
- R2: q_state reports the queried block's state in one-hot form: 3'b001 lock-tightened, 3'b010 locked, 3'b100 unlocked. q_prog_ok is high only for an unlocked block.
- R3: A write with start_we stores (addr_wdata AND (NUM_BLOCKS-1)) into both start_addr and end_addr. A write with only end_we stores the full addr_wdata into end_addr and leaves start_addr unchanged. When both strobes are high, start_we wins.
- R4: Opcode 0x23 unlocks the blocks from start_addr up to and including end_addr. Opcode 0x2A locks that same range.
- R5: When a lock or unlock walk meets a lock-tightened block, it ends at that block without error. That block and all later blocks of the range are left unchanged.
- R6: Opcode 0x2C lock-tightens the range. Blocks that are unlocked when the walk reaches them are skipped and stay unlocked.
- R7: Opcode 0x27 unlocks blocks from index 0 upward through NUM_BLOCKS-1. It stops at the first lock-tightened block.
- R8: When a walk reaches a block index of NUM_BLOCKS or more, cmd_err is set and the walk ends. cmd_err is cleared when the next command is accepted.
- R9: Whenever a walk changes a block's state, wp_status takes that new state in its low three bits (upper bits zero). A write that leaves a state as it was does not change wp_status.
- R10: A walk examines one block per clock, and busy is high for exactly one cycle per examined block. An empty range (start_addr > end_addr) takes one cycle and changes nothing. done is a one-cycle pulse in the cycle after the last examined block.
- R11: A command strobed while busy is high is ignored. A strobe with any opcode other than 0x23, 0x27, 0x2A or 0x2C is ignored: busy stays low and no state changes.
- R12: Once lock-tightened, a block stays lock-tightened until the next cold reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset, asynchronous |
| start_we | input | 1 | Write strobe for the range start register |
| end_we | input | 1 | Write strobe for the range end register |
| addr_wdata | input | DATA_W | Value written to the range registers |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| q_idx | input | IDX_W | Block index for the query port |
| start_addr | output | DATA_W | Range start register |
| end_addr | output | DATA_W | Range end register |
| wp_status | output | DATA_W | Last state written to a block by a walk |
| cmd_err | output | 1 | Walk ran past the last block |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse after a walk ends |
| q_state | output | 3 | One-hot state of block q_idx |
| q_prog_ok | output | 1 | Block q_idx is unlocked |

## Verification
The hardest situation to reach is a walk that crosses the block-count boundary. The start register is masked into range, so the walk can only reach an index past the array through an end register that is written separately with an over-large value. The stimulus does exactly that and then counts the busy cycles up to the error. Lock-tight halts also need a prepared history: a block must first be tightened, and then a lock, unlock or unlock-all walk must be launched across it. A sweep over every start/end pair, with the three range opcodes taken in turn, builds up such mixed histories. After each command, every block is compared with an arithmetic model, and so are the cycle count, the status value and the error flag.

// File: rtl/wpl_pkg.sv
package wpl_pkg;

   typedef enum logic [2:0] {
      WP_TIGHT  = 3'b001,
      WP_LOCKED = 3'b010,
      WP_OPEN   = 3'b100
   } wp_state_e;

   typedef enum logic [1:0] {
      ACT_UNLOCK = 2'd0,
      ACT_LOCK   = 2'd1,
      ACT_TIGHT  = 2'd2
   } walk_act_e;

   localparam logic [7:0] OP_UNLOCK     = 8'h23;
   localparam logic [7:0] OP_UNLOCK_ALL = 8'h27;
   localparam logic [7:0] OP_LOCK       = 8'h2A;
   localparam logic [7:0] OP_TIGHT      = 8'h2C;

   localparam int ST_W = 3;

endpackage

// File: rtl/wpl_range_regs.sv
module wpl_range_regs #(
   parameter int DATA_W = 16,
   parameter int IDX_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_we,
   input  logic              end_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] start_q,
   output logic [DATA_W-1:0] end_q
);

   localparam logic [DATA_W-1:0] IDX_MASK = DATA_W'((64'd1 << IDX_W) - 64'd1);

   logic [DATA_W-1:0] masked;
   assign masked = wdata & IDX_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         end_q   <= '0;
      end else if (start_we) begin
         start_q <= masked;
         end_q   <= masked;
      end else if (end_we) begin
         end_q   <= wdata;
      end
   end

   // R3: a start write leaves both registers equal
   p_start_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_we |=> (end_q == start_q));

   // R3: an end-only write does not disturb the start register
   p_end_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (end_we && !start_we) |=> $stable(start_q));

endmodule

// File: rtl/wpl_state_array.sv
module wpl_state_array
   import wpl_pkg::*;
#(
   parameter int NUM_BLOCKS = 1024,
   parameter int IDX_W      = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [ST_W-1:0] wr_state,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [ST_W-1:0] rd_state,
   input  logic [IDX_W-1:0] q_idx,
   output logic [ST_W-1:0] q_state
);

   logic [ST_W-1:0] blk_state [NUM_BLOCKS];

   for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            blk_state[i] <= WP_LOCKED;
         end else if (hit) begin
            blk_state[i] <= wr_state;
         end
      end

      // R12: a tightened block never leaves that state without reset
      p_tight_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (blk_state[i] == WP_TIGHT) |=> (blk_state[i] == WP_TIGHT));
   end

   assign rd_state = blk_state[rd_idx];
   assign q_state  = blk_state[q_idx];

   // R2: every state presented at the ports is one-hot
   p_onehot_query_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(q_state) == 1);

   // R12: the walker never writes a tightened block to another state
   p_no_untighten_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_idx == wr_idx && rd_state == WP_TIGHT) |-> (wr_state == WP_TIGHT));

endmodule

// File: rtl/wpl_walker.sv
module wpl_walker
   import wpl_pkg::*;
#(
   parameter int NUM_BLOCKS = 1024,
   parameter int DATA_W     = 16,
   parameter int IDX_W      = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_op,
   input  logic [DATA_W-1:0] start_q,
   input  logic [DATA_W-1:0] end_q,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [ST_W-1:0]   rd_state,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [ST_W-1:0]   wr_state,
   output logic              busy,
   output logic              done,
   output logic              cmd_err,
   output logic [DATA_W-1:0] wp_status
);

   localparam int CNT_W = DATA_W + 1;
   localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(NUM_BLOCKS);
   localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(NUM_BLOCKS - 1);
   localparam logic [DATA_W-1:0] WP_RESET = DATA_W'(WP_LOCKED);

   logic              busy_q, done_q, err_q;
   walk_act_e         act_q;
   logic [CNT_W-1:0]  cur_q, last_q;
   logic [DATA_W-1:0] wp_q;

   logic      op_known, op_all, accept;
   walk_act_e op_act;

   always_comb begin
      op_known = 1'b1;
      op_all   = 1'b0;
      op_act   = ACT_LOCK;
      case (cmd_op)
         OP_UNLOCK:     op_act = ACT_UNLOCK;
         OP_LOCK:       op_act = ACT_LOCK;
         OP_TIGHT:      op_act = ACT_TIGHT;
         OP_UNLOCK_ALL: begin
            op_act = ACT_UNLOCK;
            op_all = 1'b1;
         end
         default:       op_known = 1'b0;
      endcase
   end

   assign accept = cmd_valid && !busy_q && op_known;

   logic            past_end, in_range, halt_tight, skip_open, at_last;
   logic            changed, finish, err_set;
   logic [ST_W-1:0] new_state;

   always_comb begin
      case (act_q)
         ACT_UNLOCK: new_state = WP_OPEN;
         ACT_LOCK:   new_state = WP_LOCKED;
         default:    new_state = WP_TIGHT;
      endcase
   end

   assign rd_idx     = cur_q[IDX_W-1:0];
   assign past_end   = cur_q > last_q;
   assign in_range   = cur_q < LIMIT;
   assign at_last    = cur_q == last_q;
   assign halt_tight = (act_q != ACT_TIGHT) && (rd_state == WP_TIGHT);
   assign skip_open  = (act_q == ACT_TIGHT) && (rd_state == WP_OPEN);

   assign wr_en    = busy_q && !past_end && in_range && !halt_tight && !skip_open;
   assign wr_idx   = cur_q[IDX_W-1:0];
   assign wr_state = new_state;
   assign changed  = wr_en && (new_state != rd_state);
   assign err_set  = busy_q && !past_end && !in_range;
   assign finish   = busy_q && (past_end || !in_range || halt_tight || at_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         act_q  <= ACT_LOCK;
         cur_q  <= '0;
         last_q <= '0;
         wp_q   <= WP_RESET;
      end else begin
         done_q <= finish;
         if (accept) begin
            busy_q <= 1'b1;
            err_q  <= 1'b0;
            act_q  <= op_act;
            cur_q  <= op_all ? '0 : {1'b0, start_q};
            last_q <= op_all ? TOP_IDX : {1'b0, end_q};
         end else if (busy_q) begin
            if (finish) begin
               busy_q <= 1'b0;
            end else begin
               cur_q <= cur_q + 1'b1;
            end
            if (err_set) begin
               err_q <= 1'b1;
            end
         end
         if (changed) begin
            wp_q <= DATA_W'(new_state);
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign cmd_err   = err_q;
   assign wp_status = wp_q;

   // R10: done lasts a single cycle
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: done only follows a walking cycle
   p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   // R8: the error flag only rises out of a walk
   p_err_from_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_err) |-> $past(busy));

   // R9: the status register is quiet while no walk runs
   p_wp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(wp_status));

   // R9: the status always holds one of the three state codes
   p_wp_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wp_status) == 1);

   // R11: a strobe arriving during a walk does not restart it
   p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !finish) |=> (busy && $stable(last_q)));

endmodule

// File: rtl/wp_lock_mgr.sv
module wp_lock_mgr
   import wpl_pkg::*;
#(
   parameter  int NUM_BLOCKS = 1024,
   parameter  int DATA_W     = 16,
   localparam int IDX_W      = $clog2(NUM_BLOCKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_we,
   input  logic              end_we,
   input  logic [DATA_W-1:0] addr_wdata,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_op,
   input  logic [IDX_W-1:0]  q_idx,
   output logic [DATA_W-1:0] start_addr,
   output logic [DATA_W-1:0] end_addr,
   output logic [DATA_W-1:0] wp_status,
   output logic              cmd_err,
   output logic              busy,
   output logic              done,
   output logic [2:0]        q_state,
   output logic              q_prog_ok
);

   initial begin
      p_param_pow2: assert (NUM_BLOCKS >= 2 && (NUM_BLOCKS & (NUM_BLOCKS - 1)) == 0)
         else $error("NUM_BLOCKS must be a power of two of at least 2");
      p_param_width: assert (DATA_W > IDX_W && DATA_W >= ST_W)
         else $error("DATA_W must exceed the block index width");
   end

   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic [ST_W-1:0]  rd_state, wr_state;
   logic             wr_en;

   wpl_range_regs #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) range_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_we (start_we),
      .end_we   (end_we),
      .wdata    (addr_wdata),
      .start_q  (start_addr),
      .end_q    (end_addr)
   );

   wpl_walker #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .DATA_W     (DATA_W),
      .IDX_W      (IDX_W)
   ) walk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .start_q   (start_addr),
      .end_q     (end_addr),
      .rd_idx    (rd_idx),
      .rd_state  (rd_state),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_state  (wr_state),
      .busy      (busy),
      .done      (done),
      .cmd_err   (cmd_err),
      .wp_status (wp_status)
   );

   wpl_state_array #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .IDX_W      (IDX_W)
   ) array_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_state (wr_state),
      .rd_idx   (rd_idx),
      .rd_state (rd_state),
      .q_idx    (q_idx),
      .q_state  (q_state)
   );

   assign q_prog_ok = (q_state == WP_OPEN);

   // R2: programming is allowed exactly for unlocked blocks
   p_prog_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q_prog_ok |-> (q_state == 3'b100));

   // R11: no walk starts without a strobe
   p_start_needs_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));

endmodule

// File: tb/wp_lock_mgr_tb_top.sv
module wp_lock_mgr_tb_top;

   localparam int N       = 16;
   localparam int DW      = 16;
   localparam int IW      = 4;
   localparam int CLK_PER = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_we = 1'b0, end_we = 1'b0;
   logic [DW-1:0] addr_wdata = '0;
   logic          cmd_valid = 1'b0;
   logic [7:0]    cmd_op = '0;
   logic [IW-1:0] q_idx = '0;
   logic [DW-1:0] start_addr, end_addr, wp_status;
   logic          cmd_err, busy, done, q_prog_ok;
   logic [2:0]    q_state;

   wp_lock_mgr #(.NUM_BLOCKS(N), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_we(start_we), .end_we(end_we),
      .addr_wdata(addr_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .q_idx(q_idx), .start_addr(start_addr), .end_addr(end_addr),
      .wp_status(wp_status), .cmd_err(cmd_err), .busy(busy), .done(done),
      .q_state(q_state), .q_prog_ok(q_prog_ok)
   );

   always #(CLK_PER/2) clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;

   // model state
   logic [2:0] exp_st [N];
   int         m_start, m_end, exp_wp, exp_cyc;
   bit         exp_err;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < N; i++) exp_st[i] = 3'b010;
      m_start = 0; m_end = 0; exp_wp = 2; exp_err = 0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic check_all(input string req);
      for (int i = 0; i < N; i++) begin
         q_idx = IW'(i);
         #1;
         chk(q_state == exp_st[i], req, $sformatf("state of block %0d", i), q_state, exp_st[i]);
         chk(q_prog_ok == (exp_st[i] == 3'b100), "R2", $sformatf("prog_ok of block %0d", i),
             q_prog_ok, exp_st[i] == 3'b100);
      end
      @(negedge clk);
   endtask

   task automatic wr_start(input int v);
      start_we = 1'b1; addr_wdata = DW'(v);
      @(negedge clk);
      start_we = 1'b0;
      m_start = v & (N - 1); m_end = m_start;
   endtask

   task automatic wr_end(input int v);
      end_we = 1'b1; addr_wdata = DW'(v);
      @(negedge clk);
      end_we = 1'b0;
      m_end = v & 16'hffff;
   endtask

   task automatic set_range(input int s, input int e);
      wr_start(s);
      wr_end(e);
   endtask

   function automatic bit known_op(input logic [7:0] op);
      return op == 8'h23 || op == 8'h27 || op == 8'h2A || op == 8'h2C;
   endfunction

   task automatic model_cmd(input logic [7:0] op);
      int cur, last;
      logic [2:0] nw, st;
      exp_err = 0; exp_cyc = 0;
      cur  = (op == 8'h27) ? 0 : m_start;
      last = (op == 8'h27) ? N - 1 : m_end;
      nw = (op == 8'h2A) ? 3'b010 : (op == 8'h2C) ? 3'b001 : 3'b100;
      forever begin
         exp_cyc++;
         if (cur > last) break;
         if (cur >= N) begin exp_err = 1; break; end
         st = exp_st[cur];
         if (op == 8'h2C) begin
            if (st != 3'b100) begin
               if (nw != st) exp_wp = nw;
               exp_st[cur] = nw;
            end
         end else begin
            if (st == 3'b001) break;
            if (nw != st) exp_wp = nw;
            exp_st[cur] = nw;
         end
         if (cur == last) break;
         cur++;
      end
   endtask

   task automatic run_cmd(input logic [7:0] op, input string req);
      int cnt;
      if (known_op(op)) model_cmd(op);
      cmd_op = op; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (known_op(op)) begin
         cnt = 0;
         while (busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
         end
         chk(cnt == exp_cyc, "R10", "busy cycles", cnt, exp_cyc);
         chk(done == 1'b1, "R10", "done after walk", done, 1);
         @(negedge clk);
         chk(done == 1'b0, "R10", "done one cycle", done, 0);
      end else begin
         chk(busy == 1'b0, "R11", "busy on unknown opcode", busy, 0);
         @(negedge clk);
         chk(done == 1'b0, "R11", "done on unknown opcode", done, 0);
      end
      chk(wp_status == DW'(exp_wp), "R9", "wp_status", wp_status, exp_wp);
      chk(cmd_err == exp_err, "R8", "cmd_err", cmd_err, exp_err);
      check_all(req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : main
      logic [7:0] ops [3];
      ops[0] = 8'h23; ops[1] = 8'h2A; ops[2] = 8'h2C;

      // R1: cold reset
      repeat (2) @(negedge clk);
      chk(wp_status == 16'h0002, "R1", "wp_status in reset", wp_status, 2);
      chk(busy == 0 && done == 0 && cmd_err == 0, "R1", "flags in reset",
          {busy, done, cmd_err}, 0);
      do_reset();
      chk(start_addr == 0 && end_addr == 0, "R1", "range regs after reset",
          {start_addr, end_addr}, 0);
      chk(wp_status == 16'h0002, "R1", "wp_status after reset", wp_status, 2);
      check_all("R1");

      // R3: register writes
      wr_start(16'h0013);
      chk(start_addr == 3, "R3", "start masked", start_addr, 3);
      chk(end_addr == 3, "R3", "end mirrors start", end_addr, 3);
      wr_end(16'h0107);
      chk(end_addr == 16'h0107, "R3", "end full value", end_addr, 16'h0107);
      chk(start_addr == 3, "R3", "start untouched by end write", start_addr, 3);
      start_we = 1'b1; end_we = 1'b1; addr_wdata = 16'h0025;
      @(negedge clk);
      start_we = 1'b0; end_we = 1'b0; m_start = 5; m_end = 5;
      chk(start_addr == 5 && end_addr == 5, "R3", "start wins over end",
          {start_addr, end_addr}, {16'd5, 16'd5});

      // R4: unlock and lock ranges
      set_range(2, 9);  run_cmd(8'h23, "R4");
      set_range(4, 5);  run_cmd(8'h2A, "R4");
      // R6: tighten skips unlocked blocks
      set_range(0, 7);  run_cmd(8'h2C, "R6");
      // R5: halt at tight block
      set_range(0, 15); run_cmd(8'h23, "R5");
      set_range(3, 12); run_cmd(8'h2A, "R5");
      // R12: tight stays tight under later commands
      set_range(0, 15); run_cmd(8'h2A, "R12");
      // R10: empty range
      set_range(9, 9);  wr_end(4); run_cmd(8'h23, "R10");

      // R7: unlock all stops at first tight block
      do_reset();
      set_range(9, 9);  run_cmd(8'h2C, "R7");
      run_cmd(8'h27, "R7");
      do_reset();
      run_cmd(8'h27, "R7");

      // R8: walk past the array
      do_reset();
      set_range(14, 18); run_cmd(8'h23, "R8");
      set_range(1, 1);   run_cmd(8'h2A, "R8");

      // R11: unknown opcode and command during walk
      run_cmd(8'h55, "R11");
      run_cmd(8'h2D, "R11");
      do_reset();
      set_range(0, 15);
      model_cmd(8'h23);
      cmd_op = 8'h23; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_op = 8'h2C;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (20) @(negedge clk);
      chk(busy == 0, "R11", "walk finished", busy, 0);
      check_all("R11");

      // sweep of all ranges with rotating opcodes
      do_reset();
      for (int s = 0; s < N; s++) begin
         for (int e = s; e < N; e++) begin
            set_range(s, e);
            run_cmd(ops[(s + e) % 3], "R4");
         end
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule